// File: doc/BRIEF.md
# Dual-Timing Synchronous FIFO with Programmable Threshold Flags

This block is a single-clock FIFO of 36-bit words whose depth is a parameter (256, 512 or 1024). One port writes and another reads, each qualified by its own enable. A read and a write may land on the same clock edge, and both take effect. Which timing style the FIFO uses is fixed at master reset.

In standard timing, a word reaches the read data bus one clock after the read that fetches it. The two primary flags then mean "empty" and "full". In fall-through timing, the oldest word is moved onto the data bus without a read request, and a read consumes it. The two primary flags then mean "output word valid" and "space available".

Two threshold flags warn when the FIFO is close to empty or close to full. Their offsets start from one of three preset values chosen at master reset. Software-style logic elsewhere in the chip can later overwrite them, either as one parallel word or as a serial bit stream. A partial reset empties the FIFO and keeps the timing style and the offsets.

Top module: `dualmode_fifo`

## Requirements
- R1: Words leave the FIFO in the order they were accepted, with all 36 bits intact.
- R2: In standard timing (`fwft_sel`=0 at master reset), `out_flag`=1 means no word is stored and `in_flag`=1 means DEPTH words are stored. A read with `out_flag`=0 places the oldest word on `rd_data` after that edge, and `out_flag` falls right after the first write into an empty FIFO.
- R3: In fall-through timing (`fwft_sel`=1 at master reset), `out_flag`=1 means `rd_data` holds the oldest word. It rises after the second edge following a write into an empty FIFO. While it is high and `rd_en`=0, the flag and `rd_data` hold. A read with `out_flag`=1 consumes that word.
- R4: In fall-through timing, `in_flag`=1 while fewer than DEPTH words are held, counting the word shown on `rd_data`.
- R5: A write while the FIFO holds DEPTH words is dropped and leaves the stored data unchanged. A read while no word is available leaves `rd_data` and the flags unchanged.
- R6: A read and a write on the same edge both take effect, so the occupancy is unchanged.
- R7: `alm_empty`=1 exactly when the occupancy is at most the empty offset.
- R8: `alm_full`=1 exactly when DEPTH minus the occupancy is at most the full offset.
- R9: On the first edge after master reset is released, `fwft_sel` sets the timing style and `ofs_sel` sets both offsets: 00 gives 8, 01 gives 16, and 10 or 11 gives 64. The FIFO accepts nothing on that edge.
- R10: With `prog_par`=1, a cycle with `ofs_en`=1 loads the empty offset from `ofs_din[2*AW-1:AW]` and the full offset from `ofs_din[AW-1:0]`, where AW = log2(DEPTH).
- R11: With `prog_par`=0, each cycle with `ofs_en`=1 shifts in `ofs_sbit`. After 2*AW shifts, the first AW bits (most significant bit first) form the empty offset and the next AW bits form the full offset.
- R12: A cycle with `part_rst_n`=0 empties the FIFO and clears `rd_data`, while the timing style and both offsets are kept.
- R13: While `rst_n`=0: `out_flag`=1, `in_flag`=0, `rd_data`=0, `alm_empty`=1, `alm_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, asynchronous assert, active low |
| part_rst_n | input | 1 | Partial reset, synchronous, active low |
| fwft_sel | input | 1 | Timing style sampled after master reset (1 = fall-through) |
| ofs_sel | input | 2 | Preset offset choice sampled after master reset |
| prog_par | input | 1 | Offset programming style (1 = parallel, 0 = serial) |
| ofs_en | input | 1 | Offset load or shift strobe |
| ofs_sbit | input | 1 | Serial offset data bit |
| ofs_din | input | 2*AW | Parallel offsets {empty, full} |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Read data |
| out_flag | output | 1 | Empty (standard) or output valid (fall-through) |
| in_flag | output | 1 | Full (standard) or space available (fall-through) |
| alm_empty | output | 1 | Occupancy at or below the empty offset |
| alm_full | output | 1 | Free space at or below the full offset |

## Verification
The assertions assume that `fwft_sel` changes only while master reset is held. They also assume the offsets are never reprogrammed while the threshold flags are being judged. The bench therefore changes the timing style only inside its master reset task, and it loads offsets only while the FIFO is empty. All stimulus is driven on the falling clock edge, so every request is stable around the rising edge. Reads and writes are issued both against the flags and deliberately in violation of them, so the ignore rules are exercised.

// File: rtl/dmf_pkg.sv
`timescale 1ns/1ps
package dmf_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} mode_e;

  function automatic int unsigned preset_ofs(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8;
      2'b01:   return 16;
      default: return 64;
    endcase
  endfunction
endpackage

// File: rtl/dmf_cfg.sv
`timescale 1ns/1ps
module dmf_cfg #(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwft_sel,
  input  logic [1:0]        ofs_sel,
  input  logic              prog_par,
  input  logic              ofs_en,
  input  logic              ofs_sbit,
  input  logic [2*AW-1:0]   ofs_din,
  output logic              init,
  output dmf_pkg::mode_e    mode,
  output logic [AW-1:0]     ae_ofs,
  output logic [AW-1:0]     af_ofs
);
  import dmf_pkg::*;

  localparam int OW = 2 * AW;

  logic           init_q;
  mode_e          mode_q, mode_d;
  logic [OW-1:0]  ofs_q, ofs_d;
  logic [AW-1:0]  preset;

  always_comb begin
    preset = AW'(preset_ofs(ofs_sel));
    mode_d = mode_q;
    ofs_d  = ofs_q;
    if (init_q) begin
      mode_d = fwft_sel ? MODE_FWFT : MODE_STD;
      ofs_d  = {preset, preset};
    end else if (ofs_en) begin
      ofs_d = prog_par ? ofs_din : {ofs_q[OW-2:0], ofs_sbit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      mode_q <= MODE_STD;
      ofs_q  <= '0;
    end else begin
      init_q <= 1'b0;
      mode_q <= mode_d;
      ofs_q  <= ofs_d;
    end
  end

  assign init   = init_q;
  assign mode   = mode_q;
  assign ae_ofs = ofs_q[OW-1:AW];
  assign af_ofs = ofs_q[AW-1:0];
endmodule

// File: rtl/dmf_ram.sv
`timescale 1ns/1ps
module dmf_ram #(
  parameter int W     = 36,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dmf_flags.sv
`timescale 1ns/1ps
module dmf_flags #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          fwft,
  input  logic          ov,
  input  logic [AW:0]   occ,
  input  logic [AW-1:0] ae_ofs,
  input  logic [AW-1:0] af_ofs,
  output logic          out_flag,
  output logic          in_flag,
  output logic          alm_empty,
  output logic          alm_full
);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  logic [AW:0] free;

  always_comb begin
    free      = CAP - occ;
    alm_empty = occ <= {1'b0, ae_ofs};
    alm_full  = free <= {1'b0, af_ofs};
    if (fwft) begin
      out_flag = ov;
      in_flag  = occ < CAP;
    end else begin
      out_flag = occ == '0;
      in_flag  = occ == CAP;
    end
  end
endmodule

// File: rtl/dualmode_fifo.sv
`timescale 1ns/1ps
module dualmode_fifo #(
  parameter  int WIDTH = 36,
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              part_rst_n,
  input  logic              fwft_sel,
  input  logic [1:0]        ofs_sel,
  input  logic              prog_par,
  input  logic              ofs_en,
  input  logic              ofs_sbit,
  input  logic [2*AW-1:0]   ofs_din,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  output logic [WIDTH-1:0]  rd_data,
  output logic              out_flag,
  output logic              in_flag,
  output logic              alm_empty,
  output logic              alm_full
);
  import dmf_pkg::*;

  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);
  localparam logic [AW:0] ONE = (AW+1)'(1);

  logic [AW:0]      wp_q, wp_d, rp_q, rp_d, mem_cnt, occ;
  logic             ov_q, ov_d;
  logic [WIDTH-1:0] dout_q, dout_d, ram_q;
  logic             init, busy, fwft, wr_ok, pop;
  mode_e            mode;
  logic [AW-1:0]    ae_ofs, af_ofs;

  dmf_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .fwft_sel(fwft_sel), .ofs_sel(ofs_sel),
    .prog_par(prog_par), .ofs_en(ofs_en), .ofs_sbit(ofs_sbit),
    .ofs_din(ofs_din), .init(init), .mode(mode),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  dmf_ram #(.W(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(wr_ok), .waddr(wp_q[AW-1:0]), .wdata(wr_data),
    .raddr(rp_q[AW-1:0]), .rdata(ram_q)
  );

  assign fwft = (mode == MODE_FWFT);

  always_comb begin
    mem_cnt = wp_q - rp_q;
    occ     = mem_cnt + {{AW{1'b0}}, ov_q};
    busy    = init || !part_rst_n;
    wr_ok   = wr_en && !busy && (occ < CAP);
    pop     = !busy && (mem_cnt != '0) && (fwft ? (!ov_q || rd_en) : rd_en);
    wp_d    = wp_q;
    rp_d    = rp_q;
    ov_d    = ov_q;
    dout_d  = dout_q;
    if (!part_rst_n) begin
      wp_d   = '0;
      rp_d   = '0;
      ov_d   = 1'b0;
      dout_d = '0;
    end else begin
      if (wr_ok) wp_d = wp_q + ONE;
      if (pop) begin
        rp_d   = rp_q + ONE;
        dout_d = ram_q;
      end
      if (!fwft)                   ov_d = 1'b0;
      else if (pop)                ov_d = 1'b1;
      else if (rd_en && !init)     ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      ov_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      ov_q   <= ov_d;
      dout_q <= dout_d;
    end
  end

  dmf_flags #(.DEPTH(DEPTH), .AW(AW)) u_flags (
    .fwft(fwft), .ov(ov_q), .occ(occ), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .out_flag(out_flag), .in_flag(in_flag),
    .alm_empty(alm_empty), .alm_full(alm_full)
  );

  assign rd_data = dout_q;
endmodule

// File: rtl/dmf_checker.sv
`timescale 1ns/1ps
module dmf_checker #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int W     = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          part_rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          out_flag,
  input logic          in_flag,
  input logic [W-1:0]  rd_data,
  input logic          fwft,
  input logic          busy,
  input logic [AW:0]   occ
);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CAP); // R5

  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && out_flag && rd_en && part_rst_n) |=> $stable(rd_data)); // R5

  AST_FULL_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && in_flag && wr_en && !rd_en && part_rst_n) |=> in_flag); // R5

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && !busy && out_flag && !rd_en && part_rst_n) |=> (out_flag && $stable(rd_data))); // R3

  AST_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && !busy && rd_en && wr_en && !out_flag && !in_flag) |=> $stable(occ)); // R6

  AST_PART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !part_rst_n |=> (occ == '0 && rd_data == '0)); // R12
endmodule

bind dualmode_fifo dmf_checker #(.DEPTH(DEPTH), .AW(AW), .W(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .part_rst_n(part_rst_n), .wr_en(wr_en),
  .rd_en(rd_en), .out_flag(out_flag), .in_flag(in_flag), .rd_data(rd_data),
  .fwft(fwft), .busy(busy), .occ(occ)
);

// File: tb/dualmode_fifo_test.sv
`timescale 1ns/1ps
module dualmode_fifo_test;
  localparam int W     = 36;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n = 1'b0, part_rst_n = 1'b1, fwft_sel = 1'b0;
  logic [1:0]      ofs_sel = 2'b00;
  logic            prog_par = 1'b0, ofs_en = 1'b0, ofs_sbit = 1'b0;
  logic [2*AW-1:0] ofs_din = '0;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0]    wr_data = '0;
  logic [W-1:0]    rd_data;
  logic            out_flag, in_flag, alm_empty, alm_full;

  dualmode_fifo #(.WIDTH(W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .part_rst_n(part_rst_n), .fwft_sel(fwft_sel),
    .ofs_sel(ofs_sel), .prog_par(prog_par), .ofs_en(ofs_en),
    .ofs_sbit(ofs_sbit), .ofs_din(ofs_din), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .out_flag(out_flag), .in_flag(in_flag),
    .alm_empty(alm_empty), .alm_full(alm_full)
  );

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] sb[$];
  logic [W-1:0] pend_val = '0;
  bit pend = 0, push_now = 0, is_fwft = 0, done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // driver: one request per edge; expected words go into the scoreboard
  task automatic step(input bit wr, input logic [W-1:0] d, input bit rd);
    @(negedge clk);
    wr_en = wr; wr_data = d; rd_en = rd;
    if (wr && sb.size() < DEPTH) begin
      sb.push_back(d);
      push_now = 1;
    end
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0; push_now = 0;
  endtask

  task automatic fill(input int n, input logic [W-1:0] base);
    for (int i = 0; i < n; i++) step(1, base + W'(i), 0);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 1);
  endtask

  task automatic mrst(input bit fw, input logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0; fwft_sel = fw; ofs_sel = sel;
    sb.delete(); pend = 0; is_fwft = fw;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic par_load(input logic [AW-1:0] ae, input logic [AW-1:0] af);
    @(negedge clk);
    prog_par = 1'b1; ofs_en = 1'b1; ofs_din = {ae, af};
    @(negedge clk);
    ofs_en = 1'b0; prog_par = 1'b0;
  endtask

  task automatic ser_load(input logic [AW-1:0] ae, input logic [AW-1:0] af);
    logic [2*AW-1:0] s;
    s = {ae, af};
    prog_par = 1'b0;
    for (int i = 2*AW-1; i >= 0; i--) begin
      @(negedge clk);
      ofs_en = 1'b1; ofs_sbit = s[i];
    end
    @(negedge clk);
    ofs_en = 1'b0; ofs_sbit = 1'b0;
  endtask

  // monitor: compares words leaving the FIFO with the scoreboard (R1)
  initial begin
    forever begin
      @(posedge clk); #1;
      if (pend) begin
        chk("R1 std order", rd_data, pend_val);
        pend = 0;
      end
      #2;
      if (rst_n && part_rst_n && rd_en) begin
        if (!is_fwft) begin
          if (sb.size() - int'(push_now) > 0) begin
            pend_val = sb.pop_front();
            pend = 1;
          end
        end else if (out_flag) begin
          if (sb.size() == 0) chk("R1 fwft extra word", 1, 0);
          else chk("R1 fwft order", rd_data, sb.pop_front());
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  logic [W-1:0] held;

  initial begin
    // ---- master reset state, standard timing, preset 8 ----
    #3;
    chk("R13 out_flag", out_flag, 1);
    chk("R13 in_flag", in_flag, 0);
    chk("R13 rd_data", rd_data, 0);
    chk("R13 alm_empty", alm_empty, 1);
    chk("R13 alm_full", alm_full, 0);
    mrst(0, 2'b00);
    chk("R2 empty after reset", out_flag, 1);

    // ---- standard basics ----
    step(1, 36'h0_0000_0100, 0);
    chk("R2 empty falls after write", out_flag, 0);
    fill(7, 36'h0_0000_0101);
    chk("R7 R9 ae at 8", alm_empty, 1);
    step(1, 36'hF_0000_0108, 0);
    chk("R7 R9 ae at 9", alm_empty, 0);
    step(0, '0, 1);
    chk("R2 first read data", rd_data, 36'h0_0000_0100);
    drain(8);
    chk("R2 empty after drain", out_flag, 1);
    held = rd_data;
    chk("R1 last word", held, 36'hF_0000_0108);
    step(0, '0, 1);
    chk("R5 read empty holds data", rd_data, held);
    chk("R5 read empty holds flag", out_flag, 1);

    // ---- fill to full, overflow write dropped ----
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 36'h0_0000_1000 + W'(i), 0);
      if (i + 1 == 247) chk("R8 af at 247", alm_full, 0);
      if (i + 1 == 248) chk("R8 af at 248", alm_full, 1);
      if (i + 1 == 255) chk("R2 full at 255", in_flag, 0);
    end
    chk("R2 full at DEPTH", in_flag, 1);
    step(1, 36'hB_ADBA_DBAD, 0);
    chk("R5 full write dropped", in_flag, 1);
    drain(DEPTH);
    chk("R5 drained exactly DEPTH", out_flag, 1);

    // ---- simultaneous read and write ----
    fill(4, 36'h0_0000_2000);
    for (int j = 0; j < 3; j++) step(1, 36'h0_0000_2100 + W'(j), 1);
    drain(3);
    chk("R6 one word left", out_flag, 0);
    drain(1);
    chk("R6 empty after four reads", out_flag, 1);

    // ---- parallel offsets ----
    par_load(8'd3, 8'd5);
    fill(3, 36'h0_0000_3000);
    chk("R10 ae at 3", alm_empty, 1);
    fill(1, 36'h0_0000_3003);
    chk("R10 ae at 4", alm_empty, 0);
    fill(246, 36'h0_0000_3100);
    chk("R10 af at 250", alm_full, 0);
    fill(1, 36'h0_0000_3200);
    chk("R10 af at 251", alm_full, 1);
    drain(251);

    // ---- serial offsets ----
    ser_load(8'd2, 8'd4);
    fill(2, 36'h0_0000_4000);
    chk("R11 ae at 2", alm_empty, 1);
    fill(1, 36'h0_0000_4002);
    chk("R11 ae at 3", alm_empty, 0);
    fill(248, 36'h0_0000_4100);
    chk("R11 af at 251", alm_full, 0);
    fill(1, 36'h0_0000_4200);
    chk("R11 af at 252", alm_full, 1);

    // ---- partial reset ----
    @(negedge clk);
    part_rst_n = 1'b0;
    sb.delete();
    @(posedge clk); #1;
    part_rst_n = 1'b1;
    chk("R12 empty", out_flag, 1);
    chk("R12 rd_data cleared", rd_data, 0);
    chk("R12 af cleared", alm_full, 0);
    fill(2, 36'h0_0000_5000);
    chk("R12 ae offset kept at 2", alm_empty, 1);
    fill(1, 36'h0_0000_5002);
    chk("R12 ae offset kept at 3", alm_empty, 0);
    step(0, '0, 1);
    chk("R12 standard timing kept", rd_data, 36'h0_0000_5000);
    drain(2);

    // ---- fall-through timing, preset 16 ----
    mrst(1, 2'b01);
    chk("R3 not valid after reset", out_flag, 0);
    chk("R4 space after reset", in_flag, 1);
    step(1, 36'h0_0000_00A5, 0);
    chk("R3 not valid one edge after write", out_flag, 0);
    step(0, '0, 0);
    chk("R3 valid two edges after write", out_flag, 1);
    chk("R3 head word shown", rd_data, 36'h0_0000_00A5);
    step(0, '0, 0);
    chk("R3 head holds", rd_data, 36'h0_0000_00A5);
    step(0, '0, 1);
    chk("R3 consumed", out_flag, 0);
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 36'h0_0000_6000 + W'(i), 0);
      if (i + 1 == 16)  chk("R9 ae preset 16 at 16", alm_empty, 1);
      if (i + 1 == 17)  chk("R9 ae preset 16 at 17", alm_empty, 0);
      if (i + 1 == 239) chk("R9 af preset 16 at 239", alm_full, 0);
      if (i + 1 == 240) chk("R9 af preset 16 at 240", alm_full, 1);
      if (i + 1 == 255) chk("R4 space at 255", in_flag, 1);
    end
    chk("R4 no space at DEPTH", in_flag, 0);
    step(1, 36'hB_ADBA_DBAD, 0);
    chk("R5 fwft full write dropped", in_flag, 0);
    drain(DEPTH);
    step(0, '0, 0);
    chk("R3 none valid after drain", out_flag, 0);
    for (int k = 0; k < 40; k++) step(1, 36'h0_0000_7000 + W'(k), k[0]);
    drain(24);
    step(0, '0, 0);
    chk("R6 fwft stream drained", out_flag, 0);

    // ---- standard timing, preset 64 ----
    mrst(0, 2'b10);
    fill(64, 36'h0_0000_8000);
    chk("R9 ae preset 64 at 64", alm_empty, 1);
    fill(1, 36'h0_0000_8100);
    chk("R9 ae preset 64 at 65", alm_empty, 0);
    fill(126, 36'h0_0000_8200);
    chk("R9 af preset 64 at 191", alm_full, 0);
    fill(1, 36'h0_0000_8300);
    chk("R9 af preset 64 at 192", alm_full, 1);
    drain(192);
    chk("R2 empty at end", out_flag, 1);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule